// File: doc/BRIEF.md
# Pipelined Memory with Input Bypass

This block is a clocked single-port storage array with a dedicated write-data bus and a separate read-data bus. On each rising clock edge it captures an address, a write word and a set of controls: a write strobe, a bypass select and a pair of chip selects of opposite polarity. One edge later the output register is loaded either with the word stored at the captured address or with the captured write word itself. A write in the same cycle lands after the old word has been read, so a combined read-and-replace returns the pre-write contents.

The output is a data bus with a separate drive-enable flag instead of tristate pins. An asynchronous active-low output enable gates that flag outside the clocked path. The default build is 1024 words of 36 bits. Setting the address width to 15 gives the full 32768-word array. Reads and writes may alternate on consecutive cycles with no idle cycle. Array contents are not cleared by reset.

Top module: `pt_sram`

## Requirements
- R1: A cycle is selected only when `cs_n` is 0 and `cs` is 1 at the capturing edge. Any other combination writes nothing and leaves `dout_en` at 0 during the following cycle.
- R2: A selected cycle with `we_n`=0 and `bypass`=0 stores `din` at `addr`, and that same `din` word is presented on `dout`.
- R3: A selected cycle with `we_n`=0 and `bypass`=1 presents the word held at `addr` before the cycle, and then stores `din` there.
- R4: A selected cycle with `we_n`=1 and `bypass`=0 presents `din` on `dout` and leaves the array unchanged.
- R5: A selected cycle with `we_n`=1 and `bypass`=1 presents the stored word at `addr`.
- R6: Inputs captured at clock edge n appear on `dout`/`dout_en` after edge n+1. A write followed immediately by a read of the same address returns the new word, with no idle cycle between them.
- R7: While `oe_n` is 1, `dout_en` is 0 at once, without waiting for a clock edge. When `oe_n` returns to 0, drive resumes in the same cycle.
- R8: Right after reset, `dout_en` is 0 and `dout` is all zeros until the first selected cycle reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the pipeline registers |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write / bypass data |
| we_n | input | 1 | Active-low write strobe |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| bypass | input | 1 | 1: output array word, 0: output input word |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dout | output | DATA_W | Registered output word |
| dout_en | output | 1 | Output drive flag |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=8. With these values, every one of the sixteen addresses goes through all four selected modes with several data patterns in one short run. Each deselect combination is tried at every address, and the array is then read back to confirm that nothing changed. The small width keeps the behavioural reference array trivial, so every cycle is compared, including write-then-read pairs on consecutive cycles and output-enable pulses inside a cycle.

// File: rtl/pt_sram_pkg.sv
package pt_sram_pkg;

  // Cycle is selected when the low-true select is low and the high-true one high.
  function automatic logic chip_selected(input logic sel_low, input logic sel_high);
    return (!sel_low) && sel_high;
  endfunction

  // Output source choice: 1 takes the array word, 0 the captured input word.
  function automatic logic use_array_word(input logic bypass_sel);
    return bypass_sel;
  endfunction

  // Write happens on a selected cycle whose strobe was low.
  function automatic logic write_fires(input logic selected, input logic strobe_n);
    return selected && !strobe_n;
  endfunction

endpackage

// File: rtl/pt_sram_capture.sv
module pt_sram_capture
  import pt_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              we_n,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              bypass,
  output logic [ADDR_W-1:0] addr_r,
  output logic [DATA_W-1:0] din_r,
  output logic              we_n_r,
  output logic              byp_r,
  output logic              sel_r
);

  logic sel_now;
  assign sel_now = chip_selected(cs_n, cs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_r <= '0;
      din_r  <= '0;
      we_n_r <= 1'b1;
      byp_r  <= 1'b0;
      sel_r  <= 1'b0;
    end else begin
      addr_r <= addr;
      din_r  <= din;
      we_n_r <= we_n;
      byp_r  <= bypass;
      sel_r  <= sel_now;
    end
  end

  // R1: any deselect combination yields an unselected captured cycle
  assert_deselect_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cs) |=> !sel_r);

endmodule

// File: rtl/pt_sram_array.sv
module pt_sram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] din_r,
  output logic [DATA_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read is combinational from the captured address; the output stage
  // samples it on the same edge that the write lands, so old data is seen.
  assign rd_word = mem[addr_r];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[addr_r] <= din_r;
  end

  // R2: a fired write leaves the captured word at the captured address
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (mem[$past(addr_r)] == $past(din_r)));

endmodule

// File: rtl/pt_sram_out.sv
module pt_sram_out
  import pt_sram_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_r,
  input  logic              byp_r,
  input  logic [DATA_W-1:0] din_r,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              oe_n,
  output logic [DATA_W-1:0] q_data,
  output logic              q_drive
);

  logic q_sel;
  logic take_array;

  assign take_array = use_array_word(byp_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data <= '0;
      q_sel  <= 1'b0;
    end else begin
      q_sel <= sel_r;
      if (sel_r) q_data <= take_array ? rd_word : din_r;
    end
  end

  assign q_drive = q_sel && !oe_n;

  // R4: selected bypass cycle returns the captured input word
  assert_bypass_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_r && !byp_r) |=> (q_data == $past(din_r)));

  // R5: selected array cycle returns the word read before any write
  assert_array_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_r && byp_r) |=> (q_data == $past(rd_word)));

  // R1: an unselected captured cycle keeps the output undriven next cycle
  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_r |=> !q_sel);

endmodule

// File: rtl/pt_sram.sv
module pt_sram
  import pt_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              we_n,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              bypass,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic [ADDR_W-1:0] addr_r;
  logic [DATA_W-1:0] din_r;
  logic              we_n_r;
  logic              byp_r;
  logic              sel_r;
  logic              wr_fire;
  logic [DATA_W-1:0] rd_word;

  pt_sram_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .we_n(we_n),
    .cs_n(cs_n), .cs(cs), .bypass(bypass),
    .addr_r(addr_r), .din_r(din_r), .we_n_r(we_n_r), .byp_r(byp_r), .sel_r(sel_r)
  );

  assign wr_fire = write_fires(sel_r, we_n_r);

  pt_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arr_i (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .addr_r(addr_r),
    .din_r(din_r), .rd_word(rd_word)
  );

  pt_sram_out #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst_n(rst_n), .sel_r(sel_r), .byp_r(byp_r), .din_r(din_r),
    .rd_word(rd_word), .oe_n(oe_n), .q_data(dout), .q_drive(dout_en)
  );

endmodule

// File: tb/pt_sram_tb_top.sv
`timescale 1ns/1ps
module pt_sram_tb_top;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          we_n = 1'b1;
  logic          cs_n = 1'b1;
  logic          cs = 1'b0;
  logic          bypass = 1'b0;
  logic          oe_n = 1'b0;
  logic [DW-1:0] dout;
  logic          dout_en;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] ref_mem [NW];

  logic          e1_v = 0, e1_en = 0, e2_v = 0, e2_en = 0;
  logic [DW-1:0] e1_d = '0, e2_d = '0;
  string         e1_tag = "", e2_tag = "";

  always #2.5 clk = ~clk;

  pt_sram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .we_n(we_n),
    .cs_n(cs_n), .cs(cs), .bypass(bypass), .oe_n(oe_n),
    .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [DW-1:0] pat(input int a, input int m, input int k);
    return DW'((a * 37 + m * 11 + k * 71 + 5) & 8'hFF);
  endfunction

  task automatic chk_en(input string tag, input logic exp);
    checks++;
    if (dout_en !== exp) begin
      errors++;
      $display("FAIL %s: dout_en=%0b expected %0b", tag, dout_en, exp);
    end
  endtask

  task automatic chk_data(input string tag, input logic [DW-1:0] exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s: dout=%0h expected %0h", tag, dout, exp);
    end
  endtask

  // One cycle: check the op issued two cycles ago, then issue a new one.
  task automatic step(input logic csn_v, input logic cs_v, input logic wen_v,
                      input logic byp_v, input int a, input logic [DW-1:0] d,
                      input string tag, input bit oe_pulse);
    logic sel;
    @(negedge clk);
    if (e2_v) begin
      chk_en(e2_tag, e2_en && !oe_n);
      if (e2_en) chk_data(e2_tag, e2_d);
      if (oe_pulse) begin
        oe_n = 1'b1;
        #0.5;
        chk_en("R7", 1'b0);
        oe_n = 1'b0;
        #0.5;
        chk_en("R7", e2_en);
      end
    end
    e2_v = e1_v; e2_en = e1_en; e2_d = e1_d; e2_tag = e1_tag;
    sel = !csn_v && cs_v;
    e1_v = 1'b1;
    e1_en = sel;
    e1_tag = tag;
    e1_d = byp_v ? ref_mem[a] : d;
    if (sel && !wen_v) ref_mem[a] = d;
    cs_n = csn_v; cs = cs_v; we_n = wen_v; bypass = byp_v;
    addr = AW'(a); din = d;
  endtask

  task automatic idle();
    step(1'b1, 1'b0, 1'b1, 1'b0, 0, '0, "R1", 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk_en("R8", 1'b0);
    chk_data("R8", '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_en("R8", 1'b0);
    chk_data("R8", '0);

    // Fill every word: write with bypass output (R2)
    for (int a = 0; a < NW; a++) step(1'b0, 1'b1, 1'b0, 1'b0, a, pat(a, 0, 0), "R2", 1'b0);

    // All four selected modes at every address, two data patterns
    for (int k = 1; k < 3; k++) begin
      for (int m = 0; m < 4; m++) begin
        for (int a = 0; a < NW; a++) begin
          case (m)
            0: step(1'b0, 1'b1, 1'b0, 1'b0, a, pat(a, m, k), "R2", 1'b0);
            1: step(1'b0, 1'b1, 1'b0, 1'b1, a, pat(a, m, k), "R3", 1'b0);
            2: step(1'b0, 1'b1, 1'b1, 1'b0, a, pat(a, m, k), "R4", 1'b0);
            default: step(1'b0, 1'b1, 1'b1, 1'b1, a, pat(a, m, k), "R5", 1'b0);
          endcase
        end
      end
    end

    // R1: both deselect conditions with write attempts, then read back
    for (int a = 0; a < NW; a++) begin
      step(1'b1, 1'b1, 1'b0, 1'b0, a, pat(a, 5, 3), "R1", 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b1, a, pat(a, 6, 3), "R1", 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b0, a, pat(a, 7, 3), "R1", 1'b0);
    end
    for (int a = 0; a < NW; a++) step(1'b0, 1'b1, 1'b1, 1'b1, a, '0, "R1", 1'b0);

    // R6: write then immediate read of the same word, no idle between
    for (int a = 0; a < NW; a++) begin
      step(1'b0, 1'b1, 1'b0, 1'b1, a, pat(a, 9, 4), "R6", 1'b0);
      step(1'b0, 1'b1, 1'b1, 1'b1, a, '0, "R6", 1'b0);
    end

    // R7: output enable pulses inside cycles and held high
    for (int a = 0; a < 4; a++) step(1'b0, 1'b1, 1'b1, 1'b1, a, '0, "R7", 1'b1);
    idle();
    idle();
    step(1'b0, 1'b1, 1'b1, 1'b1, 2, '0, "R7", 1'b1);
    @(negedge clk);
    oe_n = 1'b1;
    step(1'b0, 1'b1, 1'b1, 1'b1, 3, '0, "R7", 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 4, '0, "R7", 1'b0);
    oe_n = 1'b0;
    e1_v = 1'b0;
    e2_v = 1'b0;
    idle();
    idle();
    idle();
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule